// File: doc/BRIEF.md
# Towers of Hanoi LED Move Sequencer

This block solves the three-disc Towers of Hanoi puzzle in hardware and shows every move on four LEDs. No processor is involved. The moves are computed from a move counter, with no recursion and no stack, and each move is shown as a fixed run of LED frames. Every frame is held for a parameterised number of clock cycles.

A move starts with a two-frame marker. Then come the disc code, the source peg code and the destination peg code, each followed by a blank frame. The move ends with the same two-frame marker. When all seven moves have been shown, the LEDs light fully and stay lit.

A synchronous restart input, taken from an already debounced board switch, returns the block to the first frame of the first move.

Top module: `hanoi_led_seq`

## Requirements
- R1: In the clock cycle after a clock edge at which `restart` is high, `led` shows 4'b0110, the first frame of move 1, and the dwell count starts from zero.
- R2: Every frame stays on `led` for exactly DWELL clock cycles before the next frame appears.
- R3: Each move is shown as ten frames in this order: 0110, 1001, disc, 0000, source, 0000, destination, 0000, 0110, 1001.
- R4: The disc frame is unary: disc 1 = 0001, disc 2 = 0011, disc 3 = 0111.
- R5: The peg frames are one-hot: peg 1 = 0001, peg 2 = 0010, peg 3 = 0100. The source and destination of a move always differ.
- R6: The moves, written as (disc, from, to), come in this order: (1,1,2), (2,1,3), (1,2,3), (3,1,2), (1,3,1), (2,3,2), (1,1,2). The tower ends on peg 2.
- R7: After the last frame of move 7, `led` shows 1111 and holds it until the next restart.
- R8: A restart takes priority over a frame advance in the same cycle. This holds at a dwell expiry, at the step from the last frame into the halt, and while halted. In each case R1 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| restart | input | 1 | Synchronous, active-high restart from the start of the sequence |
| led | output | 4 | Registered LED pattern |

## Verification
Two things can happen in the same cycle: a restart and the end of a frame's dwell. The end of a dwell moves the sequencer to the next frame, to the next move, or into the halt. The bench provokes the overlap by timing the restart from its own cycle count. It raises restart exactly when the dwell counter expires, exactly when the last frame of move 7 gives way to the halt, and again while halted. The reference model then expects the first marker frame, with a full dwell, in the very next cycle. Any advanced frame or shortened first frame is reported.

// File: rtl/hanoi_pkg.sv
package hanoi_pkg;
  localparam int LED_W = 4;
  typedef logic [LED_W-1:0] led_t;

  localparam led_t MARK_HI  = 4'b0110;
  localparam led_t MARK_LO  = 4'b1001;
  localparam led_t BLANK    = 4'b0000;
  localparam led_t ALL_ON   = 4'b1111;

  typedef enum logic [3:0] {
    SL_OPEN_A, SL_OPEN_B, SL_DISC, SL_GAP0, SL_SRC,
    SL_GAP1, SL_DST, SL_GAP2, SL_CLOSE_A, SL_CLOSE_B
  } slot_t;

  localparam slot_t LAST_SLOT = SL_CLOSE_B;
endpackage

// File: rtl/hanoi_move_gen.sv
module hanoi_move_gen
  import hanoi_pkg::*;
#(
  parameter int NUM_DISCS = 3
) (
  input  logic [NUM_DISCS-1:0] move_no,
  output led_t                 disc_code,
  output led_t                 src_code,
  output led_t                 dst_code
);
  localparam int MW  = NUM_DISCS;
  localparam bit ODD = (NUM_DISCS % 2) == 1;

  logic [MW:0] mv_w, lo_w, hi_w;
  logic [1:0]  src_i, dst_i;
  int          low_bit;

  function automatic led_t peg_led(input logic [1:0] idx);
    led_t v;
    case (idx)
      2'd0:    v = 4'b0001;
      2'd1:    v = ODD ? 4'b0100 : 4'b0010;
      default: v = ODD ? 4'b0010 : 4'b0100;
    endcase
    return v;
  endfunction

  always_comb begin
    mv_w  = {1'b0, move_no};
    lo_w  = mv_w & (mv_w - 1'b1);
    hi_w  = (mv_w | (mv_w - 1'b1)) + 1'b1;
    src_i = 2'(lo_w % 3);
    dst_i = 2'(hi_w % 3);
    low_bit = 0;
    for (int i = MW - 1; i >= 0; i--) begin
      if (move_no[i]) low_bit = i;
    end
    for (int j = 0; j < LED_W; j++) begin
      disc_code[j] = (j <= low_bit);
    end
    src_code = peg_led(src_i);
    dst_code = peg_led(dst_i);
  end

  // R5
  always_comb begin
    if (!$isunknown(move_no) && move_no != '0)
      peg_differ_chk: assert (src_code != dst_code);
  end
endmodule

// File: rtl/hanoi_dwell_timer.sv
module hanoi_dwell_timer #(
  parameter int DWELL = 4
) (
  input  logic clk,
  input  logic clr,
  output logic step
);
  localparam int CW = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam logic [CW-1:0] LAST = CW'(DWELL - 1);

  logic [CW-1:0] cnt;
  logic          armed = 1'b0;

  always_ff @(posedge clk) begin
    if (clr)       cnt <= '0;
    else if (step) cnt <= '0;
    else           cnt <= cnt + 1'b1;
    if (clr) armed <= 1'b1;
  end

  assign step = (cnt == LAST);

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (clr || !armed)
    cnt <= LAST);
endmodule

// File: rtl/hanoi_frame_seq.sv
module hanoi_frame_seq
  import hanoi_pkg::*;
#(
  parameter int NUM_DISCS = 3
) (
  input  logic                 clk,
  input  logic                 restart,
  input  logic                 step,
  input  led_t                 disc_code,
  input  led_t                 src_code,
  input  led_t                 dst_code,
  output logic [NUM_DISCS-1:0] move_no,
  output led_t                 led
);
  localparam logic [NUM_DISCS-1:0] LAST_MOVE = '1;

  slot_t                slot, slot_n;
  logic [NUM_DISCS-1:0] move_n;
  logic                 done, done_n;
  led_t                 led_n;
  logic                 armed = 1'b0;

  always_comb begin
    slot_n = slot;
    move_n = move_no;
    done_n = done;
    if (restart) begin
      slot_n = SL_OPEN_A;
      move_n = NUM_DISCS'(1);
      done_n = 1'b0;
    end else if (step && !done) begin
      if (slot == LAST_SLOT) begin
        slot_n = SL_OPEN_A;
        if (move_no == LAST_MOVE) done_n = 1'b1;
        else                      move_n = move_no + 1'b1;
      end else begin
        slot_n = slot_t'(slot + 1'b1);
      end
    end
  end

  always_comb begin
    if (done_n) led_n = ALL_ON;
    else begin
      case (slot_n)
        SL_OPEN_A, SL_CLOSE_A: led_n = MARK_HI;
        SL_OPEN_B, SL_CLOSE_B: led_n = MARK_LO;
        SL_DISC:               led_n = disc_code;
        SL_SRC:                led_n = src_code;
        SL_DST:                led_n = dst_code;
        default:               led_n = BLANK;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    slot    <= slot_n;
    move_no <= move_n;
    done    <= done_n;
    led     <= led_n;
    if (restart) armed <= 1'b1;
  end

  // R1
  restart_chk: assert property (@(posedge clk) restart |=> led == MARK_HI);
  // R7
  halt_hold_chk: assert property (@(posedge clk) disable iff (restart || !armed)
    done |=> (done && led == ALL_ON));
  // R2
  led_hold_chk: assert property (@(posedge clk) disable iff (restart || !armed)
    !step |=> $stable(led));
  // R3
  slot_range_chk: assert property (@(posedge clk) disable iff (restart || !armed)
    slot <= LAST_SLOT);
endmodule

// File: rtl/hanoi_led_seq.sv
module hanoi_led_seq
  import hanoi_pkg::*;
#(
  parameter int NUM_DISCS = 3,
  parameter int DWELL     = 25_000_000
) (
  input  logic       clk,
  input  logic       restart,
  output logic [3:0] led
);
  logic                 step;
  logic [NUM_DISCS-1:0] move_no;
  led_t                 disc_code, src_code, dst_code;

  hanoi_dwell_timer #(.DWELL(DWELL)) u_timer (
    .clk  (clk),
    .clr  (restart),
    .step (step)
  );

  hanoi_move_gen #(.NUM_DISCS(NUM_DISCS)) u_moves (
    .move_no   (move_no),
    .disc_code (disc_code),
    .src_code  (src_code),
    .dst_code  (dst_code)
  );

  hanoi_frame_seq #(.NUM_DISCS(NUM_DISCS)) u_frames (
    .clk       (clk),
    .restart   (restart),
    .step      (step),
    .disc_code (disc_code),
    .src_code  (src_code),
    .dst_code  (dst_code),
    .move_no   (move_no),
    .led       (led)
  );
endmodule

// File: tb/tb_hanoi_led_seq.sv
module tb_hanoi_led_seq;
  localparam int CLK_PERIOD = 10;
  localparam int DWELL_T    = 3;
  localparam int FRAMES     = 70;

  logic       clk = 1'b0;
  logic       restart;
  logic [3:0] led;

  int tests = 0, fails = 0, cycles = 0;
  int k = 0;
  bit checks_on = 1'b0;
  bit finished = 1'b0;
  string rst_tag = "R1";
  logic [3:0] expq[$];

  hanoi_led_seq #(.NUM_DISCS(3), .DWELL(DWELL_T)) dut (
    .clk(clk), .restart(restart), .led(led)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // R6: reference move list, R4 unary discs, R5 one-hot pegs, R3 frame order
  initial begin
    int md[7] = '{1, 2, 1, 3, 1, 2, 1};
    int ms[7] = '{1, 1, 2, 1, 3, 3, 1};
    int mt[7] = '{2, 3, 3, 2, 1, 2, 2};
    for (int m = 0; m < 7; m++) begin
      expq.push_back(4'b0110); expq.push_back(4'b1001);
      expq.push_back(4'((1 << md[m]) - 1)); expq.push_back(4'b0000);
      expq.push_back(4'(1 << (ms[m] - 1))); expq.push_back(4'b0000);
      expq.push_back(4'(1 << (mt[m] - 1))); expq.push_back(4'b0000);
      expq.push_back(4'b0110); expq.push_back(4'b1001);
    end
  end

  always @(posedge clk) begin
    if (restart) begin k <= 0; checks_on <= 1'b1; end
    else         k <= k + 1;
  end

  always @(negedge clk) begin
    cycles++;
    if (checks_on && !finished) begin
      int f;
      logic [3:0] e;
      string tag;
      f = k / DWELL_T;
      e = (f < FRAMES) ? expq[f] : 4'b1111;
      if (k == 0) tag = rst_tag;
      else if (f >= FRAMES) tag = "R7";
      else if (k % DWELL_T != 0) tag = "R2";
      else if (f % 10 == 0) tag = "R6";
      else if (f % 10 == 2) tag = "R4";
      else if (f % 10 == 4 || f % 10 == 6) tag = "R5";
      else tag = "R3";
      tests++;
      if (led !== e) begin
        fails++;
        $display("FAIL %s k=%0d led=%b expected=%b", tag, k, led, e);
      end
    end
    if (cycles > 20000 && !finished) begin
      fails++;
      tests++;
      $display("FAIL watchdog expired led=%b expected=end of run", led);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic pulse(input string tag);
    rst_tag = tag;
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
  endtask

  initial begin
    restart = 1'b1;
    repeat (2) @(negedge clk);
    restart = 1'b0;
    // full run plus halt (R7)
    while (k != FRAMES * DWELL_T + 30) @(negedge clk);
    pulse("R1");
    // restart partway through a move
    while (k != 100) @(negedge clk);
    pulse("R1");
    // R8: restart coinciding with a dwell expiry
    while (!(k > 40 && k % DWELL_T == DWELL_T - 1)) @(negedge clk);
    pulse("R8");
    // R8: restart coinciding with entry into halt
    while (k != FRAMES * DWELL_T - 1) @(negedge clk);
    pulse("R8");
    // R8: restart while halted
    while (k != FRAMES * DWELL_T + 12) @(negedge clk);
    pulse("R8");
    while (k != FRAMES * DWELL_T + 15) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule